// File: doc/BRIEF.md
# Bidirectional Group-Strobe Scan Chain

This block produces the sampling strobes for a column driver. It has 312 channel outputs, sampled in groups of 12 adjacent channels, so the scan has 26 stages. A start pulse arrives on one of two cascade pins and is captured on a rising clock edge. It becomes a single token that moves one stage per clock. Each stage's strobe tells the analog sample-and-hold switches of its 12 channels to take the current input. When the token leaves the final stage, a one-clock carry pulse goes out on the other cascade pin, so that the next driver in a chain can begin its own scan.

The scan-direction input chooses the order. With it high, the scan runs from the channel-1 end toward channel 312. The pin at the channel-1 end is then the start input, and the pin at the channel-312 end drives the carry. With it low, the order and both pin roles are reversed. Each pin therefore has a separate receive path, drive value and output enable. The direction is latched only when a start pulse is accepted. A reset releases both pins until the first accepted start.

Top module: `scan_strobe_chain`

## Requirements
- R1: A synchronous reset (active high) clears every strobe and the carry, and holds both cascade output enables low until a start pulse is accepted.
- R2: With `scan_up` high, a high level on `casc_lo_in` at a rising edge is accepted as a start. After that edge, strobe bit 0 is high. After each further edge, the token moves to the next higher bit.
- R3: With `scan_up` low, the start is taken from `casc_hi_in`. The token enters at bit 25 and moves toward bit 0, one bit per edge.
- R4: Strobe bit k serves channels 12k+1 through 12k+12. Bit 0 holds channels 1 to 12 and bit 25 holds channels 301 to 312.
- R5: In the cycle after the token sits in the last stage of the current direction, the carry is high on both pin drive values for exactly one cycle. At that point no strobe remains active unless a new start was accepted.
- R6: After an upward start, `casc_hi_oe`=1 and `casc_lo_oe`=0. After a downward start, `casc_lo_oe`=1 and `casc_hi_oe`=0. The two enables are never high together.
- R7: At most one strobe bit is high in any cycle.
- R8: A start accepted during a scan discards the running token and restarts at the entry stage.
- R9: A change of `scan_up` during a scan leaves the scan order and the pin enables unchanged until the next start is accepted.
- R10: A pulse on the cascade pin that is not the input for the present `scan_up` value does not start or disturb a scan.
- R11: If a start is accepted in the same cycle that the token sits in the last stage, the carry is still emitted and the new token appears at the entry stage in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| scan_up | input | 1 | 1: scan from channel 1 upward, 0: downward |
| casc_lo_in | input | 1 | Receive path of the channel-1-end cascade pin |
| casc_hi_in | input | 1 | Receive path of the channel-312-end cascade pin |
| casc_lo_out | output | 1 | Drive value of the channel-1-end pin (carry) |
| casc_hi_out | output | 1 | Drive value of the channel-312-end pin (carry) |
| casc_lo_oe | output | 1 | Output enable of the channel-1-end pin |
| casc_hi_oe | output | 1 | Output enable of the channel-312-end pin |
| grp_strobe | output | 26 | One-hot group strobe, bit k for channels 12k+1..12k+12 |

## Verification
Two functions can land on the same edge: a new start being accepted, and the carry leaving the last stage. To provoke this, the bench starts an upward scan and waits until bit 25 is the active strobe. It then raises the start pin for the next edge. After that edge it expects the carry high on the channel-312-end drive value, and in the same cycle it expects `grp_strobe` to equal bit 0 alone. In the cycle after that, the carry must be low again while the token sits on bit 1.

// File: rtl/scan_strobe_pkg.sv
package scan_strobe_pkg;

   typedef enum logic {
      SCAN_DOWN = 1'b0,
      SCAN_UP   = 1'b1
   } scan_dir_e;

endpackage

// File: rtl/cascade_port_ctrl.sv
module cascade_port_ctrl
   import scan_strobe_pkg::*;
(
   input  logic      dir_live_i,
   input  scan_dir_e dir_q_i,
   input  logic      dir_valid_i,
   input  logic      carry_i,
   input  logic      lo_in_i,
   input  logic      hi_in_i,
   output logic      start_o,
   output logic      lo_out_o,
   output logic      hi_out_o,
   output logic      lo_oe_o,
   output logic      hi_oe_o
);

   // The receiving pin follows the live direction input.
   always_comb begin
      start_o = dir_live_i ? lo_in_i : hi_in_i;
   end

   // The driving pin follows the direction latched at the last start.
   always_comb begin
      lo_oe_o  = dir_valid_i && (dir_q_i == SCAN_DOWN);
      hi_oe_o  = dir_valid_i && (dir_q_i == SCAN_UP);
      lo_out_o = carry_i;
      hi_out_o = carry_i;
   end

endmodule

// File: rtl/token_shift_reg.sv
module token_shift_reg
   import scan_strobe_pkg::*;
#(
   parameter int STAGES = 26
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              dir_live_i,
   input  scan_dir_e         dir_q_i,
   output logic [STAGES-1:0] tok_o
);

   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] tok_q;
   logic [STAGES-1:0] tok_d;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic from_lo;
      logic from_hi;
      logic entry;
      if (i == 0) begin : g_first
         assign from_lo = 1'b0;
      end else begin : g_mid_lo
         assign from_lo = tok_q[i-1];
      end
      if (i == LAST) begin : g_last
         assign from_hi = 1'b0;
      end else begin : g_mid_hi
         assign from_hi = tok_q[i+1];
      end
      assign entry = ((i == 0) && dir_live_i) || ((i == LAST) && !dir_live_i);
      assign tok_d[i] = start_i ? entry
                      : ((dir_q_i == SCAN_UP) ? from_lo : from_hi);

      if (i < LAST) begin : g_adv_chk
         AST_ADVANCE_UP: assert property (@(posedge clk) disable iff (rst)
            (!start_i && dir_q_i == SCAN_UP && tok_q[i]) |=> tok_q[i+1]); // R2
         AST_ADVANCE_DOWN: assert property (@(posedge clk) disable iff (rst)
            (!start_i && dir_q_i == SCAN_DOWN && tok_q[i+1]) |=> tok_q[i]); // R3
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tok_q <= '0;
      end else begin
         tok_q <= tok_d;
      end
   end

   assign tok_o = tok_q;

   AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(tok_q)); // R7
   AST_ENTRY_UP: assert property (@(posedge clk) disable iff (rst)
      (start_i && dir_live_i) |=> (tok_q[0] && $countones(tok_q) == 1)); // R8
   AST_ENTRY_DOWN: assert property (@(posedge clk) disable iff (rst)
      (start_i && !dir_live_i) |=> (tok_q[LAST] && $countones(tok_q) == 1)); // R3

endmodule

// File: rtl/scan_dir_carry.sv
module scan_dir_carry
   import scan_strobe_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      start_i,
   input  logic      dir_live_i,
   input  logic      tok_first_i,
   input  logic      tok_last_i,
   output scan_dir_e dir_q_o,
   output logic      dir_valid_o,
   output logic      carry_o
);

   scan_dir_e dir_q;
   logic      dir_valid_q;
   logic      carry_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         dir_q       <= SCAN_DOWN;
         dir_valid_q <= 1'b0;
         carry_q     <= 1'b0;
      end else begin
         // Leaving the exit stage of the running direction, also when a start is accepted.
         carry_q <= (dir_q == SCAN_UP) ? tok_last_i : tok_first_i;
         if (start_i) begin
            dir_q       <= dir_live_i ? SCAN_UP : SCAN_DOWN;
            dir_valid_q <= 1'b1;
         end
      end
   end

   assign dir_q_o     = dir_q;
   assign dir_valid_o = dir_valid_q;
   assign carry_o     = carry_q;

   AST_CARRY_SINGLE: assert property (@(posedge clk) disable iff (rst)
      carry_q |=> !carry_q); // R5
   AST_CARRY_CAUSE: assert property (@(posedge clk) disable iff (rst)
      carry_q |-> ($past(tok_last_i && dir_q == SCAN_UP)
                || $past(tok_first_i && dir_q == SCAN_DOWN))); // R5
   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !start_i |=> $stable(dir_q)); // R9

endmodule

// File: rtl/scan_strobe_chain.sv
module scan_strobe_chain
   import scan_strobe_pkg::*;
#(
   parameter int NUM_CHANNELS = 312,
   parameter int GROUP_SIZE   = 12,
   localparam int STAGES      = NUM_CHANNELS / GROUP_SIZE
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              scan_up,
   input  logic              casc_lo_in,
   input  logic              casc_hi_in,
   output logic              casc_lo_out,
   output logic              casc_hi_out,
   output logic              casc_lo_oe,
   output logic              casc_hi_oe,
   output logic [STAGES-1:0] grp_strobe
);

   if (GROUP_SIZE < 1) begin : g_bad_group
      $error("GROUP_SIZE must be at least 1");
   end
   if ((NUM_CHANNELS % GROUP_SIZE) != 0) begin : g_bad_split
      $error("NUM_CHANNELS must be a whole multiple of GROUP_SIZE");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("at least two stages are required");
   end

   logic              start;
   logic              carry;
   logic              dir_valid;
   scan_dir_e         dir_q;
   logic [STAGES-1:0] tok;

   cascade_port_ctrl u_port (
      .dir_live_i  (scan_up),
      .dir_q_i     (dir_q),
      .dir_valid_i (dir_valid),
      .carry_i     (carry),
      .lo_in_i     (casc_lo_in),
      .hi_in_i     (casc_hi_in),
      .start_o     (start),
      .lo_out_o    (casc_lo_out),
      .hi_out_o    (casc_hi_out),
      .lo_oe_o     (casc_lo_oe),
      .hi_oe_o     (casc_hi_oe)
   );

   token_shift_reg #(.STAGES(STAGES)) u_shift (
      .clk        (clk),
      .rst        (rst),
      .start_i    (start),
      .dir_live_i (scan_up),
      .dir_q_i    (dir_q),
      .tok_o      (tok)
   );

   scan_dir_carry u_ctl (
      .clk         (clk),
      .rst         (rst),
      .start_i     (start),
      .dir_live_i  (scan_up),
      .tok_first_i (tok[0]),
      .tok_last_i  (tok[STAGES-1]),
      .dir_q_o     (dir_q),
      .dir_valid_o (dir_valid),
      .carry_o     (carry)
   );

   assign grp_strobe = tok;

   AST_PIN_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(casc_lo_oe && casc_hi_oe)); // R6
   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      !dir_valid |-> (grp_strobe == '0 && !casc_lo_oe && !casc_hi_oe)); // R1

endmodule

// File: tb/scan_strobe_chain_tb_top.sv
module scan_strobe_chain_tb_top;

   localparam int NCH = 312;
   localparam int GSZ = 12;
   localparam int NST = NCH / GSZ;

   logic           clk = 1'b0;
   logic           rst;
   logic           scan_up;
   logic           lo_in;
   logic           hi_in;
   logic           lo_out;
   logic           hi_out;
   logic           lo_oe;
   logic           hi_oe;
   logic [NST-1:0] strobe;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   scan_strobe_chain #(.NUM_CHANNELS(NCH), .GROUP_SIZE(GSZ)) dut_i (
      .clk         (clk),
      .rst         (rst),
      .scan_up     (scan_up),
      .casc_lo_in  (lo_in),
      .casc_hi_in  (hi_in),
      .casc_lo_out (lo_out),
      .casc_hi_out (hi_out),
      .casc_lo_oe  (lo_oe),
      .casc_hi_oe  (hi_oe),
      .grp_strobe  (strobe)
   );

   typedef struct packed {
      logic           r;
      logic           up;
      logic           lo;
      logic           hi;
      logic [NST-1:0] exp_strb;
      logic           exp_carry;
      logic           exp_lo_oe;
      logic           exp_hi_oe;
   } vec_t;

   localparam int NVEC = 11;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 1'b1, 1'b0, 1'b0, 26'h0,         1'b0, 1'b0, 1'b0}, // R1 reset
      '{1'b0, 1'b1, 1'b0, 1'b0, 26'h0,         1'b0, 1'b0, 1'b0}, // R1 idle, released
      '{1'b0, 1'b1, 1'b1, 1'b0, 26'h1,         1'b0, 1'b0, 1'b1}, // R2 R6 start up
      '{1'b0, 1'b1, 1'b0, 1'b0, 26'h2,         1'b0, 1'b0, 1'b1}, // R2
      '{1'b0, 1'b1, 1'b0, 1'b0, 26'h4,         1'b0, 1'b0, 1'b1}, // R2
      '{1'b0, 1'b1, 1'b0, 1'b1, 26'h8,         1'b0, 1'b0, 1'b1}, // R10 wrong pin
      '{1'b0, 1'b0, 1'b0, 1'b0, 26'h10,        1'b0, 1'b0, 1'b1}, // R9 dir flips
      '{1'b0, 1'b1, 1'b1, 1'b0, 26'h1,         1'b0, 1'b0, 1'b1}, // R8 restart
      '{1'b0, 1'b0, 1'b0, 1'b1, 26'h2000000,   1'b0, 1'b1, 1'b0}, // R3 R6 start down
      '{1'b0, 1'b0, 1'b0, 1'b0, 26'h1000000,   1'b0, 1'b1, 1'b0}, // R3
      '{1'b1, 1'b0, 1'b0, 1'b0, 26'h0,         1'b0, 1'b0, 1'b0}  // R1 reset again
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic r, input logic up, input logic lo, input logic hi);
      @(negedge clk);
      rst = r; scan_up = up; lo_in = lo; hi_in = hi;
      @(posedge clk);
      #2;
   endtask

   function automatic logic [NST-1:0] bit_at(input int k);
      logic [NST-1:0] v;
      v = '0;
      v[k] = 1'b1;
      return v;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst = 1'b1; scan_up = 1'b1; lo_in = 1'b0; hi_in = 1'b0;

      // Vector table walk
      for (int v = 0; v < NVEC; v++) begin
         step(VECS[v].r, VECS[v].up, VECS[v].lo, VECS[v].hi);
         check("R7", "vec strobe", {6'd0, strobe}, {6'd0, VECS[v].exp_strb});
         check("R5", "vec carry", {31'd0, hi_out}, {31'd0, VECS[v].exp_carry});
         check("R6", "vec lo_oe", {31'd0, lo_oe}, {31'd0, VECS[v].exp_lo_oe});
         check("R6", "vec hi_oe", {31'd0, hi_oe}, {31'd0, VECS[v].exp_hi_oe});
      end

      // R2 R4 R5: full upward scan, channel mapping, carry on channel-312 end
      step(1'b0, 1'b1, 1'b1, 1'b0);
      for (int k = 0; k < NST; k++) begin
         check("R2", "up stage", {6'd0, strobe}, {6'd0, bit_at(k)});
         check("R4", "first channel of group", {31'd0, strobe[(GSZ*k) / GSZ]}, 32'd1);
         check("R4", "last channel of group", {31'd0, strobe[(GSZ*k + GSZ - 1) / GSZ]}, 32'd1);
         check("R5", "no early carry", {31'd0, hi_out}, 32'd0);
         if (k < NST - 1) step(1'b0, 1'b1, 1'b0, 1'b0);
      end
      step(1'b0, 1'b1, 1'b0, 1'b0);
      check("R5", "up carry high", {30'd0, hi_out, hi_oe}, 32'd3);
      check("R5", "up strobes clear", {6'd0, strobe}, 32'd0);
      step(1'b0, 1'b1, 1'b0, 1'b0);
      check("R5", "up carry one cycle", {31'd0, hi_out}, 32'd0);

      // R3 R5: full downward scan, carry on channel-1 end
      step(1'b0, 1'b0, 1'b0, 1'b1);
      for (int k = NST - 1; k >= 0; k--) begin
         check("R3", "down stage", {6'd0, strobe}, {6'd0, bit_at(k)});
         if (k > 0) step(1'b0, 1'b0, 1'b0, 1'b0);
      end
      step(1'b0, 1'b0, 1'b0, 1'b0);
      check("R5", "down carry high", {30'd0, lo_out, lo_oe}, 32'd3);
      check("R6", "down hi_oe low", {31'd0, hi_oe}, 32'd0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      check("R5", "down carry one cycle", {31'd0, lo_out}, 32'd0);

      // R11: start coincides with the token in the last stage
      step(1'b0, 1'b1, 1'b1, 1'b0);
      for (int k = 1; k < NST; k++) step(1'b0, 1'b1, 1'b0, 1'b0);
      check("R11", "token at last stage", {6'd0, strobe}, {6'd0, bit_at(NST-1)});
      step(1'b0, 1'b1, 1'b1, 1'b0);
      check("R11", "carry with restart", {31'd0, hi_out}, 32'd1);
      check("R11", "restart token", {6'd0, strobe}, 32'd1);
      step(1'b0, 1'b1, 1'b0, 1'b0);
      check("R11", "carry dropped", {31'd0, hi_out}, 32'd0);
      check("R11", "token moved", {6'd0, strobe}, 32'd2);

      // R10 in reverse: pulse on the channel-1-end pin while scanning down
      step(1'b0, 1'b0, 1'b0, 1'b1);
      step(1'b0, 1'b0, 1'b1, 1'b0);
      check("R10", "lo pin ignored when down", {6'd0, strobe}, {6'd0, bit_at(NST-2)});

      // R1: reset mid-scan
      step(1'b1, 1'b0, 1'b0, 1'b0);
      check("R1", "reset clears", {4'd0, strobe, lo_oe, hi_oe}, 32'd0);

      finish_run();
   end

endmodule